// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

This block keeps a small table of user-settable durations, in whole seconds, and counts one of them down to zero. A controller chooses which duration to use and pulses a start strobe. The block loads that duration, then lowers the count by one on each one-second tick. It raises `expired` once the count is zero. A divider inside the block makes the seconds tick from the system clock.

Any start strobe realigns the divider, so the first decrement after a start always comes one full second later. The table is filled with fixed defaults at reset. A user can overwrite any entry while the block runs by presenting an index and a value and pulsing a write strobe. The live count is brought out for a debug display.

Top module: `param_countdown`

## Requirements
- R1: After reset the table holds 6, 8, 15 and 10 at indices 0, 1, 2 and 3.
- R2: A cycle with `prog_strobe` high writes `prog_value` (0 to 15) into the entry at `prog_index`. The other entries are left unchanged.
- R3: With no start strobe, `sec_tick` is a single-cycle pulse that occurs once every TICK_DIV clock cycles.
- R4: A start strobe restarts the divider. The first `sec_tick` after a start is sampled on the TICK_DIV-th rising edge after the edge that captured the start.
- R5: A start strobe loads the count with the entry at `duration_sel`. The loaded value shows on `count_out` in the next cycle.
- R6: Each `sec_tick` with no start strobe lowers a nonzero count by exactly one. With no tick and no start, the count holds its value.
- R7: `expired` is high exactly when the count is zero. Once the count is zero it stays there until the next start strobe.
- R8: Starting with an entry of 0 makes `expired` high in the cycle after the start strobe.
- R9: When a write and a start fall in the same cycle, the start loads the entry's old value. The new value is used from the next start on.
- R10: While reset is held, `count_out` is 0, `expired` is high and `sec_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duration_sel | input | 2 | Controller's choice of the table entry to load on start |
| prog_index | input | 2 | User's choice of the table entry to overwrite |
| prog_value | input | 4 | New value in seconds for the chosen entry |
| prog_strobe | input | 1 | One-cycle write strobe for the table |
| start_timer | input | 1 | Loads the count and realigns the divider |
| expired | output | 1 | High while the count is zero |
| sec_tick | output | 1 | One-cycle pulse once per divider period |
| count_out | output | 4 | Live count, for debug display |

## Verification
The assertions assume that the inputs change only away from the rising edge and are quiet while reset is held. They also assume that the divider period is at least two cycles, so a tick can never fall in two consecutive cycles. The bench drives every input on the falling clock edge, keeps all strobes low during reset, and sets the divider period to five cycles. It uses strobes of one cycle and a single case where a write and a start coincide, so every load and every write is seen clearly on the next edge.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // Reset contents of the duration table; the pattern repeats every four entries.
  function automatic int default_secs(input int idx);
    case (idx % 4)
      0:       default_secs = 6;
      1:       default_secs = 8;
      2:       default_secs = 15;
      default: default_secs = 10;
    endcase
  endfunction
endpackage

// File: rtl/pcd_rst_sync.sv
module pcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/pcd_param_store.sv
module pcd_param_store #(
  parameter int NUM_SLOTS = 4,
  parameter int VAL_W     = 4,
  localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [VAL_W-1:0] rd_val_o
);
  logic [NUM_SLOTS-1:0][VAL_W-1:0] slot_q, slot_d;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_comb begin
      slot_d[g] = slot_q[g];
      if (wr_en_i && (wr_sel_i == SEL_W'(g))) slot_d[g] = wr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= VAL_W'(pcd_pkg::default_secs(g));
      else        slot_q[g] <= slot_d[g];
    end
  end

  // Reads see the stored value, so a write in the same cycle is not visible yet.
  assign rd_val_o = slot_q[rd_sel_i];

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> slot_q[$past(wr_sel_i)] == $past(wr_val_i));

  a_r2_no_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(slot_q));
endmodule

// File: rtl/pcd_tick_gen.sv
module pcd_tick_gen #(
  parameter int TICK_DIV = 25_000_000,
  localparam int CNT_W   = $clog2(TICK_DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  logic [CNT_W-1:0] div_q, div_d;
  logic             at_end;

  assign at_end = (div_q == CNT_W'(TICK_DIV - 1));

  always_comb begin
    if (restart_i || at_end) div_d = '0;
    else                     div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = at_end && !restart_i;

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  a_r4_no_tick_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tick_o);
endmodule

// File: rtl/pcd_countdown.sv
module pcd_countdown #(
  parameter int VAL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [VAL_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [VAL_W-1:0] cnt_o,
  output logic             expired_o
);
  logic [VAL_W-1:0] cnt_q, cnt_d;
  logic             is_zero;

  assign is_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                cnt_d = load_val_i;
    else if (tick_i && !is_zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = is_zero;

  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));

  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_q));

  a_r7_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !load_i) |=> expired_o);
endmodule

// File: rtl/param_countdown.sv
module param_countdown #(
  parameter int TICK_DIV  = 25_000_000,
  parameter int NUM_SLOTS = 4,
  parameter int VAL_W     = 4,
  localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] duration_sel,
  input  logic [SEL_W-1:0] prog_index,
  input  logic [VAL_W-1:0] prog_value,
  input  logic             prog_strobe,
  input  logic             start_timer,
  output logic             expired,
  output logic             sec_tick,
  output logic [VAL_W-1:0] count_out
);
  logic             rst_n_i;
  logic [VAL_W-1:0] sel_val;
  logic             tick;

  pcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pcd_param_store #(.NUM_SLOTS(NUM_SLOTS), .VAL_W(VAL_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_en_i  (prog_strobe),
    .wr_sel_i (prog_index),
    .wr_val_i (prog_value),
    .rd_sel_i (duration_sel),
    .rd_val_o (sel_val)
  );

  pcd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .restart_i (start_timer),
    .tick_o    (tick)
  );

  pcd_countdown #(.VAL_W(VAL_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load_i     (start_timer),
    .load_val_i (sel_val),
    .tick_i     (tick),
    .cnt_o      (count_out),
    .expired_o  (expired)
  );

  assign sec_tick = tick;

  a_r7_expired_tracks_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    expired == (count_out == '0));
endmodule

// File: tb/sim_param_countdown.sv
module sim_param_countdown;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] duration_sel = '0;
  logic [1:0] prog_index = '0;
  logic [3:0] prog_value = '0;
  logic       prog_strobe = 1'b0;
  logic       start_timer = 1'b0;
  logic       expired, sec_tick;
  logic [3:0] count_out;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  param_countdown #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .duration_sel(duration_sel), .prog_index(prog_index),
    .prog_value(prog_value), .prog_strobe(prog_strobe), .start_timer(start_timer),
    .expired(expired), .sec_tick(sec_tick), .count_out(count_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural reference: table, elapsed edges since last realign, seconds left.
  int  m_slot [4];
  int  m_age, m_left;
  bit  m_s1, m_s2;

  always @(posedge clk) begin
    bit exp_tick;
    if (!rst_n) begin
      m_slot = '{6, 8, 15, 10};
      m_age = 0; m_left = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (m_s2) begin
        if (start_timer) begin
          m_left = m_slot[duration_sel];
          m_age  = 0;
        end else begin
          if (((m_age + 1) % DIV) == 0 && m_left > 0) m_left--;
          m_age++;
        end
        if (prog_strobe) m_slot[prog_index] = prog_value;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
    #1;
    exp_tick = (((m_age + 1) % DIV) == 0) && !start_timer;
    chk("R6 count vs model", count_out, m_left);
    chk("R7 expired vs model", expired, m_left == 0);
    chk("R3 tick vs model", sec_tick, exp_tick);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_with(input int sel);
    duration_sel = 2'(sel);
    start_timer  = 1'b1;
    @(negedge clk);
    start_timer  = 1'b0;
  endtask

  task automatic write_slot(input int idx, input int val);
    prog_index  = 2'(idx);
    prog_value  = 4'(val);
    prog_strobe = 1'b1;
    @(negedge clk);
    prog_strobe = 1'b0;
  endtask

  initial begin
    int n;
    int defs [4] = '{6, 8, 15, 10};
    cyc(3);
    chk("R10 count in reset", count_out, 0);
    chk("R10 expired in reset", expired, 1);
    chk("R10 tick in reset", sec_tick, 0);
    rst_n = 1'b1;
    cyc(4);

    n = 0;
    for (int i = 0; i < 4 * DIV; i++) begin
      cyc(1);
      if (sec_tick) n++;
    end
    chk("R3 ticks in four periods", n, 4);

    for (int i = 0; i < 4; i++) begin
      start_with(i);
      chk("R1 R5 default loaded", count_out, defs[i]);
      chk("R5 not expired after load", expired, 0);
    end

    start_with(0);
    n = 0;
    while (!expired && !done) begin
      cyc(1);
      n++;
    end
    chk("R6 R7 edges until expiry", n, 6 * DIV);
    cyc(3 * DIV);
    chk("R7 count held at zero", count_out, 0);
    chk("R7 expired held", expired, 1);

    cyc(2);
    start_with(1);
    cyc(DIV - 1);
    chk("R4 first tick a full period after start", sec_tick, 1);
    chk("R4 count before first tick", count_out, 8);
    cyc(1);
    chk("R4 R6 count after first tick", count_out, 7);

    write_slot(2, 3);
    start_with(2);
    chk("R2 rewritten entry", count_out, 3);
    start_with(1);
    chk("R2 other entry untouched", count_out, 8);

    write_slot(3, 0);
    chk("R8 expired low before zero start", expired, 0);
    start_with(3);
    chk("R8 expired right after zero start", expired, 1);
    chk("R8 count zero", count_out, 0);

    prog_index = 2'd1; prog_value = 4'd2; prog_strobe = 1'b1;
    start_with(1);
    prog_strobe = 1'b0;
    chk("R9 same-cycle start uses old value", count_out, 8);
    start_with(1);
    chk("R9 later start uses new value", count_out, 2);

    cyc(2);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule